// File: doc/BRIEF.md
# Digital VCO Period-Locking Loop

This block holds an external voltage-controlled oscillator at a period chosen by the host. It runs on a precise reference clock and watches the oscillator's output. Over a long run of oscillator periods it counts how many reference cycles pass. It compares that count with a 16-bit target and moves a 12-bit DAC control word one step toward the target after each measurement.

Each update interval has two halves of 2^WINDOW_LOG2 oscillator periods each (32768 by default). The first half lets the oscillator settle after a DAC change and is not measured. In the second half the block counts reference cycles. Only the low 16 bits of the count are kept, because the high bits never change over the tuning range. The comparison uses the signed 16-bit difference (count − target), so a count that wraps past the 16-bit boundary still gives the correct direction.

A count within ±1 of the target leaves the DAC word unchanged and raises the lock flag. While the enable is low the DAC word is frozen. After the enable rises, the block waits STARTUP_CYCLES reference cycles (about 10 ms by default) before the first interval begins.

Top module: `vco_period_lock`

## Requirements
- R1: After reset, `dac_word` equals DAC_INIT, and `dac_update` and `locked` are low.
- R2: While `enable` is low, `dac_word` keeps its value, `locked` is low, and no `dac_update` pulse occurs, whatever `vco_in` and `target_count` do.
- R3: After `enable` rises, the loop waits STARTUP_CYCLES reference cycles, then a settle window of 2^WINDOW_LOG2 oscillator rising edges, then a measure window of 2^WINDOW_LOG2 rising edges. The first possible DAC change therefore falls no earlier than STARTUP_CYCLES + (2^(WINDOW_LOG2+1) − 1) oscillator periods after enable.
- R4: The measured value is the number of reference cycles between the rising edge that ends the settle window and the 2^WINDOW_LOG2-th rising edge after it, taken modulo 2^16. Each oscillator rising edge is counted once, after a two-flop synchronizer.
- R5: If the signed 16-bit value (count − target) lies between −1 and +1, the DAC word is unchanged, no pulse is issued, and `locked` goes high.
- R6: With the default polarity, a signed difference above +1 (period too long) raises `dac_word` by exactly 1. A difference below −1 lowers it by exactly 1.
- R7: The difference is taken modulo 2^16 as a signed value. For example, a count of 160 against a target of 0xFFFF is a difference of +161, and the word is raised.
- R8: `dac_word` saturates at 0xFFF and 0x000 and never wraps.
- R9: `dac_update` is high for exactly one cycle, the cycle in which `dac_word` shows a new value, and at no other time.
- R10: A measurement outside the deadband clears `locked`. Another update interval always follows the decision directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (time base) |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_in | input | 1 | Oscillator output, asynchronous to clk |
| enable | input | 1 | Runs the loop; when low, the DAC word is frozen |
| target_count | input | 16 | Target low 16 bits of the cycle count |
| dac_word | output | 12 | DAC control word |
| dac_update | output | 1 | One-cycle pulse when dac_word changes |
| locked | output | 1 | Last measurement fell inside the deadband |

## Verification
The bench runs the oscillator at a fixed integer period, so each measurement window gives an exactly known count. It then places the target just inside and just outside the ±1 deadband. A design with an off-by-one count, or with a deadband that is too wide or too narrow, would step when it should hold, or hold when it should step.

A target of 0xFFFF against a small count checks the wrapped signed comparison. An unsigned comparison would step the word the wrong way.

The time of the first pulse after enable is checked against a window. A design that skipped the settle half or the startup wait would update too early.

Driving the word into 0xFFF checks that it stops there and issues no pulse. Toggling the enable with a mismatched target checks that the frozen word really stays put.

// File: rtl/vpl_pkg.sv
package vpl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETTLE,
        ST_MEASURE
    } vpl_state_e;
endpackage

// File: rtl/vpl_edge_sync.sv
module vpl_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // sh[1] is the second synchronizer stage; sh[2] holds its previous value
    assign rise_o = s_q.sh[1] & ~s_q.sh[2];
endmodule

// File: rtl/vpl_dac_stepper.sv
module vpl_dac_stepper #(
    parameter int            DAC_W    = 12,
    parameter logic [11:0]   DAC_INIT = 12'h800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en_i,
    input  logic             step_up_i,
    output logic [DAC_W-1:0] dac_o,
    output logic             upd_o
);
    localparam logic [DAC_W-1:0] DAC_MAX = '1;
    localparam logic [DAC_W-1:0] DAC_MIN = '0;

    typedef struct packed {
        logic [DAC_W-1:0] dac;
        logic             upd;
    } step_t;

    step_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (step_en_i) begin
            if (step_up_i && s_q.dac != DAC_MAX) begin
                s_d.dac = s_q.dac + DAC_W'(1);
                s_d.upd = 1'b1;
            end else if (!step_up_i && s_q.dac != DAC_MIN) begin
                s_d.dac = s_q.dac - DAC_W'(1);
                s_d.upd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.dac <= DAC_INIT[DAC_W-1:0];
            s_q.upd <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_o = s_q.dac;
    assign upd_o = s_q.upd;

    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_o != $past(dac_o)) |->
            ((dac_o == $past(dac_o) + DAC_W'(1)) || (dac_o == $past(dac_o) - DAC_W'(1))));

    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o == (dac_o != $past(dac_o)));

    assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && step_up_i && dac_o == DAC_MAX) |=> (dac_o == DAC_MAX));

    assert_sat_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !step_up_i && dac_o == DAC_MIN) |=> (dac_o == DAC_MIN));
endmodule

// File: rtl/vco_period_lock.sv
module vco_period_lock #(
    parameter int          WINDOW_LOG2     = 15,
    parameter int          CNT_W           = 16,
    parameter int          DAC_W           = 12,
    parameter logic [11:0] DAC_INIT        = 12'h800,
    parameter int          STARTUP_CYCLES  = 1000000,
    parameter int          DEADBAND        = 1,
    parameter bit          LONG_RAISES_DAC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vco_in,
    input  logic             enable,
    input  logic [CNT_W-1:0] target_count,
    output logic [DAC_W-1:0] dac_word,
    output logic             dac_update,
    output logic             locked
);
    import vpl_pkg::*;

    localparam int                      WAIT_W   = $clog2(STARTUP_CYCLES + 1);
    localparam logic [WAIT_W-1:0]       WAIT_END = WAIT_W'(STARTUP_CYCLES - 1);
    localparam logic [WINDOW_LOG2-1:0]  EDGE_END = '1;
    localparam logic signed [CNT_W-1:0] DB_POS   = CNT_W'(DEADBAND);
    localparam logic signed [CNT_W-1:0] DB_NEG   = -DB_POS;

    typedef struct packed {
        vpl_state_e             state;
        logic [WAIT_W-1:0]      wait_cnt;
        logic [WINDOW_LOG2-1:0] edge_cnt;
        logic [CNT_W-1:0]       cyc_cnt;
        logic                   locked;
    } ctl_t;

    ctl_t s_d, s_q;
    logic vco_rise;
    logic step_en, step_up;
    logic [CNT_W-1:0]        meas;
    logic signed [CNT_W-1:0] diff;

    vpl_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vco_in),
        .rise_o  (vco_rise)
    );

    // cyc_cnt restarts at zero the cycle after the opening edge
    assign meas = s_q.cyc_cnt + CNT_W'(1);
    assign diff = $signed(meas - target_count);

    always_comb begin
        s_d     = s_q;
        step_en = 1'b0;
        step_up = 1'b0;
        if (!enable) begin
            s_d.state    = ST_IDLE;
            s_d.wait_cnt = '0;
            s_d.edge_cnt = '0;
            s_d.cyc_cnt  = '0;
            s_d.locked   = 1'b0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    s_d.wait_cnt = '0;
                    s_d.state    = ST_WAIT;
                end
                ST_WAIT: begin
                    if (s_q.wait_cnt == WAIT_END) begin
                        s_d.state    = ST_SETTLE;
                        s_d.edge_cnt = '0;
                    end else begin
                        s_d.wait_cnt = s_q.wait_cnt + WAIT_W'(1);
                    end
                end
                ST_SETTLE: begin
                    if (vco_rise) begin
                        if (s_q.edge_cnt == EDGE_END) begin
                            s_d.state    = ST_MEASURE;
                            s_d.edge_cnt = '0;
                            s_d.cyc_cnt  = '0;
                        end else begin
                            s_d.edge_cnt = s_q.edge_cnt + WINDOW_LOG2'(1);
                        end
                    end
                end
                ST_MEASURE: begin
                    s_d.cyc_cnt = s_q.cyc_cnt + CNT_W'(1);
                    if (vco_rise) begin
                        if (s_q.edge_cnt == EDGE_END) begin
                            s_d.state    = ST_SETTLE;
                            s_d.edge_cnt = '0;
                            if (diff > DB_POS) begin
                                step_en    = 1'b1;
                                step_up    = LONG_RAISES_DAC;
                                s_d.locked = 1'b0;
                            end else if (diff < DB_NEG) begin
                                step_en    = 1'b1;
                                step_up    = !LONG_RAISES_DAC;
                                s_d.locked = 1'b0;
                            end else begin
                                s_d.locked = 1'b1;
                            end
                        end else begin
                            s_d.edge_cnt = s_q.edge_cnt + WINDOW_LOG2'(1);
                        end
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.wait_cnt <= '0;
            s_q.edge_cnt <= '0;
            s_q.cyc_cnt  <= '0;
            s_q.locked   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    vpl_dac_stepper #(
        .DAC_W    (DAC_W),
        .DAC_INIT (DAC_INIT)
    ) u_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en_i (step_en),
        .step_up_i (step_up),
        .dac_o     (dac_word),
        .upd_o     (dac_update)
    );

    assign locked = s_q.locked;

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(dac_word));

    assert_unlocked_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked);

    assert_lock_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !dac_update);

    assert_no_step_while_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !dac_update);
endmodule

// File: tb/vco_period_lock_bench.sv
module vco_period_lock_bench;
    localparam int K       = 4;
    localparam int VHALF   = 5;
    localparam int VPER    = 2 * VHALF;
    localparam int STARTUP = 50;
    localparam int CNT     = (1 << K) * VPER;   // 160 cycles per measure window
    localparam int IVAL    = 2 * CNT;           // one update interval

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] target = '0;
    logic [11:0] dac_word;
    logic        dac_update;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic [11:0] prev_dac = 12'hFFD;
    logic        prev_upd = 1'b0;

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (VHALF) @(negedge clk);
            vco = ~vco;
        end
    end

    vco_period_lock #(
        .WINDOW_LOG2    (K),
        .DAC_INIT       (12'hFFD),
        .STARTUP_CYCLES (STARTUP)
    ) u_vco_period_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .vco_in       (vco),
        .enable       (enable),
        .target_count (target),
        .dac_word     (dac_word),
        .dac_update   (dac_update),
        .locked       (locked)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // R9 monitor: pulse only together with a one-step change, never two cycles long
    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_update) begin
                strobes++;
                check_eq("R9 pulse width", int'(prev_upd), 0);
                check_eq("R9 changed on pulse", int'(dac_word != prev_dac), 1);
            end else if (dac_word != prev_dac) begin
                check_eq("R9 change without pulse", int'(dac_word), int'(prev_dac));
            end
            prev_dac = dac_word;
            prev_upd = dac_update;
        end
    end

    task automatic wait_strobe(int limit, output int waited);
        waited = 0;
        while (!dac_update && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic disable_loop();
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check_eq("R1 dac reset", int'(dac_word), 12'hFFD);
        check_eq("R1 pulse reset", int'(dac_update), 0);
        check_eq("R1 lock reset", int'(locked), 0);
    endtask

    task automatic t_hold_when_off();
        int s0;
        s0 = strobes;
        target = 16'h0000;
        repeat (3 * IVAL) @(negedge clk);
        check_eq("R2 dac frozen", int'(dac_word), 12'hFFD);
        check_eq("R2 no pulses", strobes - s0, 0);
        check_eq("R2 not locked", int'(locked), 0);
    endtask

    task automatic t_first_step_timing();
        int w;
        target = 16'(CNT - 2);                  // count - target = +2 -> raise
        @(negedge clk);
        enable = 1'b1;
        wait_strobe(3 * IVAL, w);
        checks++;
        if (w < STARTUP + (2 * (1 << K) - 1) * VPER || w > STARTUP + 2 * (1 << K) * VPER + 8) begin
            fails++;
            $display("FAIL R3 first update at %0d cycles expected %0d..%0d", w,
                     STARTUP + (2 * (1 << K) - 1) * VPER, STARTUP + 2 * (1 << K) * VPER + 8);
        end
        @(negedge clk);
        check_eq("R6 raise by one", int'(dac_word), 12'hFFE);
        check_eq("R10 unlocked after step", int'(locked), 0);
        disable_loop();
    endtask

    task automatic t_deadband_lock();
        int s0;
        s0 = strobes;
        target = 16'(CNT);
        @(negedge clk);
        enable = 1'b1;
        repeat (STARTUP + 3 * IVAL) @(negedge clk);
        check_eq("R5 locked at exact", int'(locked), 1);
        target = 16'(CNT - 1);
        repeat (2 * IVAL) @(negedge clk);
        check_eq("R5 locked at target-1", int'(locked), 1);
        target = 16'(CNT + 1);
        repeat (2 * IVAL) @(negedge clk);
        check_eq("R5 locked at target+1", int'(locked), 1);
        check_eq("R5 dac unchanged", int'(dac_word), 12'hFFE);
        check_eq("R4 R5 no pulses", strobes - s0, 0);
    endtask

    task automatic t_unlock_lower();
        int w;
        target = 16'(CNT + 10);                 // count below target -> lower
        wait_strobe(3 * IVAL, w);
        @(negedge clk);
        check_eq("R6 lower by one", int'(dac_word), 12'hFFD);
        check_eq("R10 lock cleared", int'(locked), 0);
        disable_loop();
        check_eq("R2 lock low after disable", int'(locked), 0);
    endtask

    task automatic t_wrap_compare();
        int w;
        target = 16'hFFFF;                      // 160 - 0xFFFF = +161 mod 2^16
        @(negedge clk);
        enable = 1'b1;
        wait_strobe(STARTUP + 3 * IVAL, w);
        @(negedge clk);
        check_eq("R7 wrapped diff raises", int'(dac_word), 12'hFFE);
        disable_loop();
    endtask

    task automatic t_saturate();
        int w;
        int s0;
        target = 16'(CNT - 2);
        @(negedge clk);
        enable = 1'b1;
        wait_strobe(STARTUP + 3 * IVAL, w);
        @(negedge clk);
        check_eq("R8 reaches top", int'(dac_word), 12'hFFF);
        s0 = strobes;
        repeat (3 * IVAL) @(negedge clk);
        check_eq("R8 held at top", int'(dac_word), 12'hFFF);
        check_eq("R8 no pulse at top", strobes - s0, 0);
        target = 16'(CNT + 2);
        wait_strobe(3 * IVAL, w);
        @(negedge clk);
        check_eq("R6 lower from top", int'(dac_word), 12'hFFE);
        disable_loop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold_when_off();
        t_first_step_timing();
        t_deadband_lock();
        t_unlock_lower();
        t_wrap_compare();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule